// File: doc/BRIEF.md
# Two-way data cache controller with lockable way and per-access write policy

The block is a two-way set-associative data cache of 8 KB (128 sets, two 4 KB ways, 32-byte lines of eight 32-bit words). It sits between a CPU load/store port and a word-wide memory port. Every access carries a two-bit attribute that picks how the access treats the cache: bypass it, write back, write through and allocate on a store miss, or write through without allocating. A plain control pin keeps way A out of replacement, so code or data placed there stays resident while way B serves every miss.

The CPU side is valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so a request stays pending for as long as a fill, a writeback or a memory write runs. Completion is a single-cycle `rsp_valid` pulse, with load data on `rsp_rdata`. The response has no back-pressure. The memory side is also valid/ready. A request holds its address, direction and data stable until `mem_ready` takes it. A write is finished when it is taken. A read returns one `mem_rvalid` pulse with the word some cycles later, and only one read is outstanding at a time. `lock_a` must stay stable while an access is in progress.

Top module: `dc_ctrl_top`

## Requirements
- R1: An address splits into tag = bits 31..12, set = bits 11..5 and word = bits 4..2. Once a line is filled, loads to any of its eight words hit, return the stored word and cause no memory traffic.
- R2: A cacheable load miss reads all eight words of the line from memory in ascending word order. It raises `rsp_valid` only after the last word arrives, and it returns the requested word.
- R3: While `lock_a` is 1, every miss fills way B and never way A. Lines already in way A keep hitting.
- R4: Attribute 0 (uncached): a load does one memory read of the word and a store does one memory write. No tag, data or dirty state changes, so a line cached at that address keeps its old value.
- R5: Attribute 1 (writeback): a store hit updates the cached word, makes no memory access and marks the line dirty. A dirty victim is written back as eight words in ascending order before its refill starts.
- R6: Attribute 1 store miss: the line is filled first and then updated and marked dirty. The store itself is never written to memory.
- R7: Attribute 2 (write-through, allocate): a store hit updates the cache, does one memory write and leaves the dirty bit as it was. A store miss fills the line first, then updates it and writes memory.
- R8: Attribute 3 (write-through, no allocate): a store miss does only one memory write and allocates no line. A store hit updates the cache and memory and leaves the dirty bit as it was.
- R9: With `lock_a` at 0, the victim is the way of the set that was used least recently. A hit or a fill makes that way the most recent one. After reset, way A is the first victim of every set.
- R10: `req_ready` is low whenever the memory port is busy. `rsp_valid` is high for exactly one cycle per access. A memory request holds valid, direction, address and data until `mem_ready` takes it.
- R11: Reset invalidates every line and clears every dirty and LRU bit by sweeping one set per cycle. `req_ready` rises exactly 128 cycles after reset release, and `rsp_valid` and `mem_valid` stay low until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_a | input | 1 | Keep way A out of replacement |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Controller idle; request is taken this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_attr | input | 2 | 0 uncached, 1 writeback, 2 write-through allocate, 3 write-through no allocate |
| req_addr | input | 32 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, valid with rsp_valid |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory takes the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address on the memory port |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned read word |

## Verification
The bench aims at conflicts in a few sets. There, a wrong victim choice shows up as an extra refill of a line that should have stayed, or as a locked line in way A being thrown out. A dirty eviction is compared against the exact expected list of memory operations, so words written back out of order, or a clean line that still writes memory, fail that comparison. The stale-line case loads a line, stores to the same address with the uncached attribute, then loads it cached again. A design that let the uncached store touch the cache would return the new value. The write-through-without-allocate miss is followed by a cached load of the same line, which must refill from memory and return the stored word. A design that allocated on that miss would hit instead.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    ATTR_UNC  = 2'd0,
    ATTR_WB   = 2'd1,
    ATTR_WTA  = 2'd2,
    ATTR_WTNA = 2'd3
  } attr_e;

  typedef enum logic [3:0] {
    ST_INIT, ST_IDLE, ST_LOOK, ST_EVICT, ST_FILL, ST_FWAIT, ST_MWR, ST_MRD, ST_MRW
  } state_e;
endpackage

// File: rtl/dc_tagstore.sv
module dc_tagstore #(
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic [SET_W-1:0]      set_i,
  output logic [1:0][TAG_W-1:0] tag_o,
  output logic [1:0]            valid_o,
  output logic [1:0]            dirty_o,
  output logic                  lru_o,
  input  logic                  init_we,
  input  logic [SET_W-1:0]      init_set,
  input  logic                  fill_we,
  input  logic                  fill_way,
  input  logic [TAG_W-1:0]      fill_tag,
  input  logic                  dirty_we,
  input  logic                  dirty_way,
  input  logic                  lru_we,
  input  logic                  lru_val
);
  logic [1:0][TAG_W-1:0] tagm [SETS];
  logic [1:0]            vld  [SETS];
  logic [1:0]            drt  [SETS];
  logic                  lru  [SETS];

  assign tag_o   = tagm[set_i];
  assign valid_o = vld[set_i];
  assign dirty_o = drt[set_i];
  assign lru_o   = lru[set_i];

  // the state is cleared by the sweep after reset, not by the reset pin
  always_ff @(posedge clk) begin
    if (init_we) begin
      vld[init_set] <= '0;
      drt[init_set] <= '0;
      lru[init_set] <= 1'b0;
    end else begin
      if (fill_we) begin
        tagm[set_i][fill_way] <= fill_tag;
        vld[set_i][fill_way]  <= 1'b1;
        drt[set_i][fill_way]  <= 1'b0;
      end
      if (dirty_we) drt[set_i][dirty_way] <= 1'b1;
      if (lru_we)   lru[set_i] <= lru_val;
    end
  end
endmodule

// File: rtl/dc_dataram.sv
module dc_dataram #(
  parameter int SETS   = 128,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS),
  localparam int IDX_W = 1 + SET_W + OFF_W
) (
  input  logic              clk,
  input  logic              rd_way,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [OFF_W-1:0]  rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic              wr_way,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [OFF_W-1:0]  wr_word,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] ram [2**IDX_W];

  assign rd_data = ram[{rd_way, rd_set, rd_word}];

  always_ff @(posedge clk) begin
    if (we) ram[{wr_way, wr_set, wr_word}] <= wr_data;
  end
endmodule

// File: rtl/dc_ctrl_top.sv
module dc_ctrl_top
  import dc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 128,
  parameter int WORDS  = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - SET_W - OFF_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_a,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [1:0]        req_attr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [OFF_W-1:0] LAST_W = OFF_W'(WORDS - 1);
  localparam logic [SET_W-1:0] LAST_S = SET_W'(SETS - 1);

  state_e            state;
  logic              q_we;
  attr_e             q_attr;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [OFF_W-1:0]  cnt;
  logic              vict;
  logic [SET_W-1:0]  init_set;

  logic [SET_W-1:0]  q_set;
  logic [OFF_W-1:0]  q_word;
  logic [TAG_W-1:0]  q_tag;
  assign q_set  = q_addr[OFF_W+2 +: SET_W];
  assign q_word = q_addr[2 +: OFF_W];
  assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];

  logic [1:0][TAG_W-1:0] ts_tag;
  logic [1:0]            ts_valid, ts_dirty;
  logic                  ts_lru;
  logic [1:0]            hit;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit[w] = ts_valid[w] && (ts_tag[w] == q_tag);
  end

  logic hit_any, hit_way, cacheable, new_vict;
  assign hit_any   = |hit;
  assign hit_way   = hit[1];
  assign cacheable = (q_attr != ATTR_UNC);
  assign new_vict  = lock_a ? 1'b1 : ts_lru;

  logic in_look_hit;
  assign in_look_hit = (state == ST_LOOK) && cacheable && hit_any;

  // data storage: reads follow the victim while evicting, else the hit way
  logic              ram_we, ram_wway;
  logic [OFF_W-1:0]  ram_wword;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;
  logic              fill_we;

  assign fill_we   = (state == ST_FWAIT) && mem_rvalid;
  assign ram_we    = (in_look_hit && q_we) || fill_we;
  assign ram_wway  = fill_we ? vict : hit_way;
  assign ram_wword = fill_we ? cnt : q_word;
  assign ram_wdata = fill_we ? mem_rdata : q_wdata;

  dc_dataram #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .rd_way  ((state == ST_EVICT) ? vict : hit_way),
    .rd_set  (q_set),
    .rd_word ((state == ST_EVICT) ? cnt : q_word),
    .rd_data (ram_rdata),
    .we      (ram_we),
    .wr_way  (ram_wway),
    .wr_set  (q_set),
    .wr_word (ram_wword),
    .wr_data (ram_wdata)
  );

  logic tag_fill;
  assign tag_fill = fill_we && (cnt == LAST_W);

  dc_tagstore #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .set_i     (q_set),
    .tag_o     (ts_tag),
    .valid_o   (ts_valid),
    .dirty_o   (ts_dirty),
    .lru_o     (ts_lru),
    .init_we   (state == ST_INIT),
    .init_set  (init_set),
    .fill_we   (tag_fill),
    .fill_way  (vict),
    .fill_tag  (q_tag),
    .dirty_we  (in_look_hit && q_we && (q_attr == ATTR_WB)),
    .dirty_way (hit_way),
    .lru_we    (in_look_hit),
    .lru_val   (~hit_way)
  );

  // memory port
  assign req_ready = (state == ST_IDLE);
  assign mem_valid = (state == ST_EVICT) || (state == ST_FILL) ||
                     (state == ST_MWR)   || (state == ST_MRD);
  assign mem_we    = (state == ST_EVICT) || (state == ST_MWR);
  assign mem_wdata = (state == ST_EVICT) ? ram_rdata : q_wdata;

  always_comb begin
    case (state)
      ST_EVICT: mem_addr = {ts_tag[vict], q_set, cnt, 2'b00};
      ST_FILL:  mem_addr = {q_tag, q_set, cnt, 2'b00};
      default:  mem_addr = {q_addr[ADDR_W-1:2], 2'b00};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_INIT;
      init_set  <= '0;
      q_we      <= 1'b0;
      q_attr    <= ATTR_UNC;
      q_addr    <= '0;
      q_wdata   <= '0;
      cnt       <= '0;
      vict      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_INIT: begin
          init_set <= init_set + 1'b1;
          if (init_set == LAST_S) state <= ST_IDLE;
        end
        ST_IDLE: if (req_valid) begin
          q_we    <= req_we;
          q_attr  <= attr_e'(req_attr);
          q_addr  <= req_addr;
          q_wdata <= req_wdata;
          state   <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!cacheable) begin
            state <= q_we ? ST_MWR : ST_MRD;
          end else if (hit_any) begin
            if (q_we && q_attr != ATTR_WB) begin
              state <= ST_MWR;
            end else begin
              rsp_valid <= 1'b1;
              rsp_rdata <= q_we ? '0 : ram_rdata;
              state     <= ST_IDLE;
            end
          end else if (q_we && q_attr == ATTR_WTNA) begin
            state <= ST_MWR;
          end else begin
            vict  <= new_vict;
            cnt   <= '0;
            state <= (ts_valid[new_vict] && ts_dirty[new_vict]) ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_W) state <= ST_FILL;
        end
        ST_FILL: if (mem_ready) state <= ST_FWAIT;
        ST_FWAIT: if (mem_rvalid) begin
          cnt   <= cnt + 1'b1;
          state <= (cnt == LAST_W) ? ST_LOOK : ST_FILL;
        end
        ST_MWR: if (mem_ready) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
          state     <= ST_IDLE;
        end
        ST_MRD: if (mem_ready) state <= ST_MRW;
        ST_MRW: if (mem_rvalid) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_rdata;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOK) |-> !(hit[0] && hit[1])) else $error("line in both ways"); // R1

  AST_LOCK_FILLS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_fill && lock_a) |-> vict) else $error("locked way refilled"); // R3

  AST_UNC_NO_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (q_attr != ATTR_UNC)) else $error("uncached access wrote cache"); // R4

  AST_EVICT_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EVICT && mem_ready && cnt != LAST_W) |=>
      (mem_we && mem_addr == $past(mem_addr) + ADDR_W'(4))) else $error("writeback order"); // R5

  AST_WTNA_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL) |-> !(q_we && q_attr == ATTR_WTNA)) else $error("no-allocate store filled"); // R8

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid) else $error("response longer than one cycle"); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
    else $error("memory request dropped or changed"); // R10
endmodule

// File: tb/tb_dc_ctrl_top.sv
module tb_dc_ctrl_top;
  localparam int SETS  = 128;
  localparam int WORDS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_a = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [1:0]  req_attr = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  dc_ctrl_top dut (
    .clk(clk), .rst_n(rst_n), .lock_a(lock_a),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_attr(req_attr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int total = 0;
  int bad = 0;
  int mon_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memories ----------------
  bit [31:0] bmem [bit [31:0]];
  bit [31:0] emem [bit [31:0]];

  function automatic bit [31:0] init_val(input bit [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic bit [31:0] brd(input bit [31:0] a);
    return bmem.exists(a) ? bmem[a] : init_val(a);
  endfunction
  function automatic bit [31:0] erd(input bit [31:0] a);
    return emem.exists(a) ? emem[a] : init_val(a);
  endfunction

  bit [64:0] expq[$];
  bit [64:0] actq[$];

  // memory responder and port monitor, all at the falling edge
  bit        rd_pend = 0;
  int        rd_dly = 0;
  bit [31:0] rd_addr = 0;
  bit        hold_pend = 0;
  bit [31:0] hold_addr = 0;
  bit        prev_rsp = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_pend && (!mem_valid || mem_addr != hold_addr)) mon_err++;
        if (req_ready && mem_valid) mon_err++;
        if (prev_rsp && rsp_valid) mon_err++;
      end
      prev_rsp = rsp_valid;
      mem_ready  = 1'b0;
      mem_rvalid = 1'b0;
      if (rd_pend) begin
        if (rd_dly == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = brd(rd_addr);
          rd_pend    = 0;
        end else rd_dly--;
      end else if (rst_n && mem_valid && ($urandom % 4 != 0)) begin
        mem_ready = 1'b1;
        actq.push_back({mem_we, mem_addr, mem_we ? mem_wdata : 32'h0});
        if (mem_we) bmem[mem_addr] = mem_wdata;
        else begin
          rd_pend = 1;
          rd_addr = mem_addr;
          rd_dly  = $urandom % 3;
        end
      end
      hold_pend = mem_valid && !mem_ready;
      hold_addr = mem_addr;
    end
  end

  // ---------------- reference cache ----------------
  bit [19:0] m_tag [2][SETS];
  bit        m_vld [2][SETS];
  bit        m_drt [2][SETS];
  bit        m_lru [SETS];
  bit [31:0] m_data[2][SETS][WORDS];

  task automatic model(input bit we, input bit [31:0] a, input bit [31:0] wd,
                       input bit [1:0] at, output bit [31:0] rd);
    int s, w, h;
    bit [19:0] tg;
    bit v;
    bit [31:0] la;
    s = int'(a[11:5]); w = int'(a[4:2]); tg = a[31:12]; rd = 0; h = -1;
    expq.delete();
    if (at == 2'd0) begin
      if (we) begin expq.push_back({1'b1, a, wd}); emem[a] = wd; end
      else begin expq.push_back({1'b0, a, 32'h0}); rd = erd(a); end
      return;
    end
    for (int i = 0; i < 2; i++) if (m_vld[i][s] && m_tag[i][s] == tg) h = i;
    if (h < 0) begin
      if (we && at == 2'd3) begin
        expq.push_back({1'b1, a, wd}); emem[a] = wd;
        return;
      end
      v = lock_a ? 1'b1 : m_lru[s];
      if (m_vld[v][s] && m_drt[v][s])
        for (int i = 0; i < WORDS; i++) begin
          la = {m_tag[v][s], 7'(s), 3'(i), 2'b00};
          expq.push_back({1'b1, la, m_data[v][s][i]});
          emem[la] = m_data[v][s][i];
        end
      for (int i = 0; i < WORDS; i++) begin
        la = {tg, 7'(s), 3'(i), 2'b00};
        expq.push_back({1'b0, la, 32'h0});
        m_data[v][s][i] = erd(la);
      end
      m_vld[v][s] = 1; m_drt[v][s] = 0; m_tag[v][s] = tg;
      h = int'(v);
    end
    m_lru[s] = (h == 0);
    if (!we) rd = m_data[h][s][w];
    else begin
      m_data[h][s][w] = wd;
      if (at == 2'd1) m_drt[h][s] = 1;
      else begin expq.push_back({1'b1, a, wd}); emem[a] = wd; end
    end
  endtask

  // one access at the CPU port, checked against the reference
  task automatic acc(input bit we, input bit [31:0] a, input bit [31:0] wd,
                     input bit [1:0] at, input string req);
    bit [31:0] er;
    int t;
    int mis;
    model(we, a, wd, at, er);
    actq.delete();
    t = 0;
    while (!req_ready) begin
      @(negedge clk); t++;
      if (t > 5000) begin chk(0, req, "request not taken", 0, 1); return; end
    end
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd; req_attr = at;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid) begin
      @(negedge clk); t++;
      if (t > 5000) begin chk(0, req, "no response", 0, 1); return; end
    end
    chk(actq.size() == expq.size(), req, "memory op count", actq.size(), expq.size());
    mis = -1;
    for (int i = 0; i < actq.size() && i < expq.size(); i++)
      if (mis < 0 && actq[i] != expq[i]) mis = i;
    if (mis >= 0) chk(0, req, "memory op", actq[mis], expq[mis]);
    else chk(1, req, "memory op", 0, 0);
    if (!we) chk(rsp_rdata == er, req, "load data", rsp_rdata, er);
  endtask

  function automatic bit [31:0] ad(input int tg, input int s, input int w);
    return {20'(tg), 7'(s), 3'(w), 2'b00};
  endfunction

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h1BAD_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state and sweep length
    chk(req_ready == 1'b0, "R11", "ready at release", req_ready, 0);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid at release", rsp_valid, 0);
    chk(mem_valid == 1'b0, "R11", "mem_valid at release", mem_valid, 0);
    n = 0;
    while (!req_ready && n < 1000) begin n++; @(negedge clk); end
    chk(n == SETS, "R11", "cycles until ready", n, SETS);
    acc(0, ad(1, 5, 3), 0, 2'd1, "R11 first load misses");

    // R1 / R2: whole-line hits after the fill
    for (int w = 0; w < WORDS; w++) acc(0, ad(1, 5, w), 0, 2'd1, "R1 line hit");
    acc(0, ad(1, 6, 7), 0, 2'd1, "R2 load miss fill");

    // R9: LRU victim selection
    acc(0, ad(2, 5, 0), 0, 2'd1, "R9 second way fill");
    acc(0, ad(1, 5, 1), 0, 2'd1, "R9 touch way A");
    acc(0, ad(3, 5, 2), 0, 2'd1, "R9 replace least recent");
    acc(0, ad(1, 5, 4), 0, 2'd1, "R9 recent line kept");
    acc(0, ad(2, 5, 0), 0, 2'd1, "R9 replaced line misses");

    // R5: writeback store hit, then dirty eviction
    acc(1, ad(1, 5, 2), 32'hDEAD_0001, 2'd1, "R5 store hit no memory write");
    acc(0, ad(1, 5, 2), 0, 2'd1, "R5 store hit readback");
    acc(0, ad(5, 5, 0), 0, 2'd1, "R5 fill other way");
    acc(0, ad(6, 5, 0), 0, 2'd1, "R5 dirty eviction ascending");
    acc(0, ad(1, 5, 2), 0, 2'd1, "R5 written back value");

    // R6: writeback store miss
    acc(1, ad(7, 9, 4), 32'hC0DE_0006, 2'd1, "R6 store miss fills");
    acc(0, ad(7, 9, 4), 0, 2'd1, "R6 store miss readback");

    // R7: write-through with allocate
    acc(1, ad(7, 9, 5), 32'h1111_0007, 2'd2, "R7 store hit writes memory");
    acc(1, ad(8, 9, 1), 32'h2222_0007, 2'd2, "R7 store miss fill then write");
    acc(0, ad(8, 9, 1), 0, 2'd1, "R7 readback");

    // R8: write-through without allocate
    acc(1, ad(9, 20, 3), 32'h3333_0008, 2'd3, "R8 store miss memory only");
    acc(0, ad(9, 20, 3), 0, 2'd1, "R8 no line allocated");
    acc(1, ad(9, 20, 6), 32'h4444_0008, 2'd3, "R8 store hit");

    // R4: uncached leaves a cached line stale
    acc(0, ad(10, 30, 2), 0, 2'd1, "R4 cache the line");
    acc(1, ad(10, 30, 2), 32'h5555_0004, 2'd0, "R4 uncached store");
    acc(0, ad(10, 30, 2), 0, 2'd1, "R4 cached copy unchanged");
    acc(0, ad(10, 30, 2), 0, 2'd0, "R4 uncached load");

    // R3: lock keeps way A
    acc(0, ad(1, 40, 0), 0, 2'd1, "R3 fill A");
    acc(0, ad(2, 40, 0), 0, 2'd1, "R3 fill B");
    acc(0, ad(2, 40, 1), 0, 2'd1, "R3 make A least recent");
    lock_a = 1'b1;
    acc(0, ad(3, 40, 0), 0, 2'd1, "R3 locked miss fills B");
    acc(0, ad(1, 40, 5), 0, 2'd1, "R3 way A kept");
    acc(1, ad(4, 40, 2), 32'h6666_0003, 2'd1, "R3 store miss into B");
    acc(0, ad(5, 40, 0), 0, 2'd1, "R3 dirty B evicted");
    acc(0, ad(1, 40, 6), 0, 2'd1, "R3 way A still kept");
    lock_a = 1'b0;

    // constrained random mix over a few crowded sets
    for (int k = 0; k < 800; k++) begin
      int sets_pick[4] = '{0, 1, 64, 127};
      if ($urandom % 20 == 0) lock_a = ~lock_a;
      acc(1'($urandom % 2),
          ad(int'($urandom % 5), sets_pick[$urandom % 4], int'($urandom % 8)),
          $urandom, 2'($urandom % 4), "R1 R2 R5 R7 R9 random mix");
    end

    chk(mon_err == 0, "R10", "port rule violations", mon_err, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule